// File: doc/BRIEF.md
# Reset-Gated Selectable Rate Step Clock

This block derives a slow CPU step clock from a fast reference clock. A two-bit rate select picks one of three output rates: two slow ones, so that register contents can be read by eye while a program steps, and one fast one for normal running. The step clock is a registered square wave in the reference domain. A one-cycle tick marks each of its rising edges, so downstream logic can use it as a clock enable instead of a derived clock.

While reset is high, the step clock is held low and makes no transitions. When reset is released, the output always begins with a full low half-period before its first rising edge. Downstream registers therefore have time to settle before the first active edge. Each half-period length is computed at elaboration from the reference frequency and the target rate. A change of rate select is only picked up at the next half-period boundary, so a phase is never cut short.

Top module: `stepRateClock`

## Requirements
- R1: With rateSel 2'b00 the half-period is HS = max(1, REF_HZ / (2*SLOW_HZ)) reference cycles. With 2'b01 it is HM, computed the same way from MID_HZ, and with 2'b10 it is HF, computed from FAST_HZ. stepClk stays high for exactly one half-period and low for exactly one half-period.
- R2: In a cycle where rst is high on the clock edge, stepClk and tick are low after that edge, and they stay low with no transitions for as long as rst stays high.
- R3: After rst falls, stepClk stays low for exactly H reference cycles before it rises, where H is the half-period of the rateSel value present at the last reset edge. The count includes the cycle in which rst is first low.
- R4: rateSel 2'b11 selects the same half-period as 2'b00 (HS).
- R5: tick is high for exactly one reference cycle, namely the first cycle in which stepClk is high. It is low in every other cycle.
- R6: A change of rateSel does not shorten or lengthen the half-period in progress. The new length applies from the next half-period onward.
- R7: Every high or low phase of stepClk outside reset lasts exactly HS, HM or HF cycles, so no runt phase occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset; holds the step clock off |
| rateSel | input | 2 | Rate code: 00 slow, 01 mid, 10 fast, 11 slow |
| stepClk | output | 1 | Square-wave step clock, registered in the clk domain |
| tick | output | 1 | One-cycle pulse on each rising edge of stepClk |

## Verification
The assertions check on every cycle that the output is held low during reset, that tick appears exactly with a rise of stepClk and never two cycles in a row, and that every finished phase has one of the three legal lengths. Some properties depend on stimulus history, so only the bench scenarios can show them: that each select code maps to its own half-period, that the first phase after reset release is low and has the full length, and that a rate change in mid-phase waits for the boundary. The bench also runs a behavioural model alongside the design and compares both outputs on every cycle.

// File: rtl/stepClkPkg.sv
package stepClkPkg;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'b00,
    RATE_MID  = 2'b01,
    RATE_FAST = 2'b10,
    RATE_ALT  = 2'b11
  } rateCode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic holdOff;    // force output low, clear counter
    logic toggle;     // half-period boundary reached
    logic loadLimit;  // capture new half-period length
  } stepStrobe_t;

  // Half-period length in reference cycles, never below one
  function automatic int unsigned halfCycles(input int unsigned refHz,
                                             input int unsigned outHz);
    int unsigned h;
    h = refHz / (2 * outHz);
    if (h < 1) h = 1;
    return h;
  endfunction

  function automatic int unsigned maxOf3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/stepRateTable.sv
module stepRateTable
  import stepClkPkg::*;
#(
  parameter int unsigned REF_HZ  = 50_000_000,
  parameter int unsigned SLOW_HZ = 10,
  parameter int unsigned MID_HZ  = 400,
  parameter int unsigned FAST_HZ = 165_000,
  parameter int unsigned CW      = 22
) (
  input  logic [1:0]    rateSel,
  output logic [CW-1:0] halfSel
);

  localparam int unsigned HALF_SLOW = halfCycles(REF_HZ, SLOW_HZ);
  localparam int unsigned HALF_MID  = halfCycles(REF_HZ, MID_HZ);
  localparam int unsigned HALF_FAST = halfCycles(REF_HZ, FAST_HZ);
  localparam int unsigned CODES     = 4;

  logic [CW-1:0] halfTable [CODES];

  // Code 11 falls back to the slow rate (R4)
  for (genvar c = 0; c < CODES; c++) begin : g_code
    localparam int unsigned H = (c == int'(RATE_FAST)) ? HALF_FAST :
                                (c == int'(RATE_MID))  ? HALF_MID  : HALF_SLOW;
    assign halfTable[c] = CW'(H);
  end

  assign halfSel = halfTable[rateSel];

endmodule

// File: rtl/stepControl.sv
module stepControl
  import stepClkPkg::*;
(
  input  logic        rst,
  input  logic        terminal,
  output stepStrobe_t strobe
);

  always_comb begin
    strobe           = '0;
    strobe.holdOff   = rst;
    strobe.toggle    = !rst && terminal;
    // Limit reloads during reset and at each boundary only (R6)
    strobe.loadLimit = rst || terminal;
  end

endmodule

// File: rtl/stepDatapath.sv
module stepDatapath
  import stepClkPkg::*;
#(
  parameter int unsigned CW = 22
) (
  input  logic          clk,
  input  stepStrobe_t   strobe,
  input  logic [CW-1:0] nextHalf,
  output logic          terminal,
  output logic          stepClk,
  output logic          tick
);

  logic [CW-1:0] phaseCnt;
  logic [CW-1:0] halfLimit;
  logic          clkQ;
  logic          tickQ;

  always_ff @(posedge clk) begin
    if (strobe.holdOff) begin
      phaseCnt <= '0;
      clkQ     <= 1'b0;
      tickQ    <= 1'b0;
    end else if (strobe.toggle) begin
      phaseCnt <= '0;
      clkQ     <= ~clkQ;
      tickQ    <= ~clkQ;
    end else begin
      phaseCnt <= phaseCnt + CW'(1);
      tickQ    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.loadLimit) halfLimit <= nextHalf;
  end

  assign terminal = (phaseCnt == halfLimit - CW'(1));
  assign stepClk  = clkQ;
  assign tick     = tickQ;

endmodule

// File: rtl/stepRateClock.sv
module stepRateClock
  import stepClkPkg::*;
#(
  parameter int unsigned REF_HZ  = 50_000_000,
  parameter int unsigned SLOW_HZ = 10,
  parameter int unsigned MID_HZ  = 400,
  parameter int unsigned FAST_HZ = 165_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rateSel,
  output logic       stepClk,
  output logic       tick
);

  localparam int unsigned MAX_HALF = maxOf3(halfCycles(REF_HZ, SLOW_HZ),
                                            halfCycles(REF_HZ, MID_HZ),
                                            halfCycles(REF_HZ, FAST_HZ));
  localparam int unsigned CW = $clog2(MAX_HALF + 1);

  logic [CW-1:0] halfSel;
  logic          terminal;
  stepStrobe_t   strobe;

  stepRateTable #(
    .REF_HZ(REF_HZ), .SLOW_HZ(SLOW_HZ), .MID_HZ(MID_HZ),
    .FAST_HZ(FAST_HZ), .CW(CW)
  ) u_table (
    .rateSel(rateSel),
    .halfSel(halfSel)
  );

  stepControl u_ctrl (
    .rst(rst),
    .terminal(terminal),
    .strobe(strobe)
  );

  stepDatapath #(.CW(CW)) u_dp (
    .clk(clk),
    .strobe(strobe),
    .nextHalf(halfSel),
    .terminal(terminal),
    .stepClk(stepClk),
    .tick(tick)
  );

endmodule

// File: rtl/stepRateClockChecker.sv
module stepRateClockChecker
  import stepClkPkg::*;
#(
  parameter int unsigned REF_HZ  = 50_000_000,
  parameter int unsigned SLOW_HZ = 10,
  parameter int unsigned MID_HZ  = 400,
  parameter int unsigned FAST_HZ = 165_000
) (
  input logic clk,
  input logic rst,
  input logic stepClk,
  input logic tick
);

  localparam int unsigned HS = halfCycles(REF_HZ, SLOW_HZ);
  localparam int unsigned HM = halfCycles(REF_HZ, MID_HZ);
  localparam int unsigned HF = halfCycles(REF_HZ, FAST_HZ);

  logic        rstQ    = 1'b0;
  logic        prevClk = 1'b0;
  int unsigned runLen  = 0;

  always_ff @(posedge clk) begin
    rstQ <= rst;
    // R2: one edge after a reset edge the outputs are low
    if (rstQ) begin
      p_hold_low_r2: assert (!stepClk && !tick)
        else $error("stepClk/tick not held low in reset");
    end
    if (rst) begin
      runLen  <= 0;
      prevClk <= 1'b0;
    end else if (stepClk != prevClk) begin
      // R7: finished phase has a legal length
      p_phase_len_r7: assert (runLen == HS || runLen == HM || runLen == HF)
        else $error("phase length %0d not legal", runLen);
      runLen  <= 1;
      prevClk <= stepClk;
    end else begin
      runLen <= runLen + 1;
    end
  end

  // R5: tick only on a rise of stepClk
  p_tick_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
    tick |-> $rose(stepClk));

  // R5: every rise of stepClk carries a tick
  p_rise_has_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(stepClk) |-> tick);

  // R5: tick lasts one cycle
  p_tick_single_r5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

bind stepRateClock stepRateClockChecker #(
  .REF_HZ(REF_HZ), .SLOW_HZ(SLOW_HZ), .MID_HZ(MID_HZ), .FAST_HZ(FAST_HZ)
) u_chk (
  .clk(clk),
  .rst(rst),
  .stepClk(stepClk),
  .tick(tick)
);

// File: tb/tb_stepRateClock.sv
module tb_stepRateClock;

  localparam int REF = 330_000;
  localparam int SLOWR = 10;
  localparam int MIDR = 400;
  localparam int FASTR = 165_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rateSel = 2'b00;
  logic       stepClk;
  logic       tick;

  int checks = 0;
  int errors = 0;
  bit compareOn = 1'b0;

  always #5 clk = ~clk;

  stepRateClock #(
    .REF_HZ(REF), .SLOW_HZ(SLOWR), .MID_HZ(MIDR), .FAST_HZ(FASTR)
  ) dut (
    .clk(clk), .rst(rst), .rateSel(rateSel), .stepClk(stepClk), .tick(tick)
  );

  function automatic int expHalf(input logic [1:0] sel);
    int hz;
    int h;
    case (sel)
      2'b01:   hz = MIDR;
      2'b10:   hz = FASTR;
      default: hz = SLOWR;
    endcase
    h = REF / (2 * hz);
    if (h < 1) h = 1;
    return h;
  endfunction

  // Behavioural reference model
  bit mClk = 0, mTick = 0;
  int mElapsed = 0, mLen = 1;
  always @(posedge clk) begin
    if (rst) begin
      mClk = 0; mTick = 0; mElapsed = 0; mLen = expHalf(rateSel);
    end else begin
      mElapsed++;
      mTick = 0;
      if (mElapsed >= mLen) begin
        mClk = !mClk;
        mTick = mClk;
        mElapsed = 0;
        mLen = expHalf(rateSel);
      end
    end
  end

  always @(negedge clk) begin
    if (compareOn) begin
      checks++;
      if (stepClk !== mClk || tick !== mTick) begin
        errors++;
        $display("FAIL R1 model compare: stepClk=%0b tick=%0b expected %0b %0b at %0t",
                 stepClk, tick, mClk, mTick, $time);
      end
    end
  end

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measureRun(input logic level, output int n);
    n = 0;
    while (stepClk === level && n < 40000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic resetWith(input logic [1:0] sel);
    rst = 1'b1;
    rateSel = sel;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int ticks;
    repeat (5) @(negedge clk);
    compareOn = 1'b1;
    checkEq("R2 reset stepClk", int'(stepClk), 0);
    checkEq("R2 reset tick", int'(tick), 0);

    // Fast rate
    resetWith(2'b10);
    rst = 1'b0;
    measureRun(1'b0, n); checkEq("R3 fast low-first", n, expHalf(2'b10));
    measureRun(1'b1, n); checkEq("R1 fast high", n, expHalf(2'b10));
    ticks = 0;
    for (int i = 0; i < 20; i++) begin
      if (tick) ticks++;
      @(negedge clk);
    end
    checkEq("R5 fast tick count", ticks, 10);

    // Reset hold
    resetWith(2'b01);
    for (int i = 0; i < 5; i++) begin
      checkEq("R2 held low", int'(stepClk), 0);
      @(negedge clk);
    end

    // Mid rate
    rst = 1'b0;
    measureRun(1'b0, n); checkEq("R3 mid low-first", n, expHalf(2'b01));
    checkEq("R5 tick at rise", int'(tick), 1);
    measureRun(1'b1, n); checkEq("R1 mid high", n, expHalf(2'b01));
    ticks = 0;
    for (int i = 0; i < 4 * expHalf(2'b01); i++) begin
      if (tick) ticks++;
      @(negedge clk);
    end
    checkEq("R5 mid tick count", ticks, 2);

    // Slow rate
    resetWith(2'b00);
    rst = 1'b0;
    measureRun(1'b0, n); checkEq("R3 slow low-first", n, expHalf(2'b00));
    measureRun(1'b1, n); checkEq("R1 slow high", n, expHalf(2'b00));

    // Code 11 behaves as slow
    resetWith(2'b11);
    rst = 1'b0;
    measureRun(1'b0, n); checkEq("R4 code 11 low", n, expHalf(2'b00));

    // Rate change in mid-phase
    resetWith(2'b01);
    rst = 1'b0;
    for (int i = 0; i < 100; i++) @(negedge clk);
    rateSel = 2'b10;
    measureRun(1'b0, n); checkEq("R6 old phase kept", n + 100, expHalf(2'b01));
    measureRun(1'b1, n); checkEq("R6 new rate high", n, expHalf(2'b10));
    measureRun(1'b0, n); checkEq("R7 new rate low", n, expHalf(2'b10));

    // Reset while running
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      checkEq("R2 stopped stepClk", int'(stepClk), 0);
      checkEq("R2 stopped tick", int'(tick), 0);
      @(negedge clk);
    end

    compareOn = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule